// File: doc/BRIEF.md
# Column Shift Repair for an SRAM Data Path

This block sits between the logical data word of an embedded SRAM and its physical bit columns. The physical array is one column wider than the logical word, and the extra column sits at the most-significant end. When a column is found faulty, a repair configuration (enable plus column index) is loaded. The block then decodes it into a thermometer mask of multiplexer selects. Every logical bit at or above the faulty index moves one column up, toward the spare. Every logical bit below the faulty index keeps its own column. Software and logic using the memory see the same N-bit word whether or not a repair is in place.

Both the write path and the read path are combinational through the multiplexers. Only the repair configuration is registered. A load takes effect after the clock edge that captures it. A load requested while the surrounding memory reports an access in flight is dropped, so the mapping never changes under a live access. An index outside the logical width is not applied: the mapping stays direct and an error flag is raised. The block has no streaming interface and therefore no back-pressure. Every pin is plain control or data.

Top module: `col_shift_repair`

## Requirements
- R1: After reset, repair is inactive and `cfg_err` is 0.
- R2: When `cfg_we` is 1 and `acc_active` is 0 at a rising edge, `cfg_en` and `cfg_addr` are captured, and the new mapping applies from that edge onward.
- R3: A `cfg_we` pulse while `acc_active` is 1 is ignored: the mapping and `cfg_err` keep their previous values.
- R4: With repair inactive, `phy_wdata[i] = wdata[i]` for every i below N, `phy_wdata[N]` (the spare) is 0, and `rdata[i] = phy_rdata[i]`; `phy_rdata[N]` has no effect.
- R5: With repair active at index a, every column j < a is unshifted: `phy_wdata[j] = wdata[j]` and `rdata[j] = phy_rdata[j]`.
- R6: With repair active at index a, `phy_wdata[j] = wdata[j-1]` for every a < j <= N, so bit N-1 lands in the spare column.
- R7: With repair active at index a, the faulty column is driven with 0 (`phy_wdata[a] = 0`).
- R8: With repair active at index a, `rdata[i] = phy_rdata[i+1]` for every i >= a, and `phy_rdata[a]` has no effect.
- R9: Loading `cfg_en` = 1 with `cfg_addr` >= N leaves the mapping direct (as in R4) and sets `cfg_err`. Any later accepted load with `cfg_en` = 0, or with `cfg_addr` < N, clears `cfg_err`.
- R10: For any single faulty column a in 0..N-1 with repair loaded at a, a word written through the block into storage whose column a is stuck reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load request for the repair configuration |
| cfg_en | input | 1 | Repair enable value to load |
| cfg_addr | input | ADDR_W | Faulty column index to load |
| acc_active | input | 1 | Memory access in flight; blocks configuration loads |
| wdata | input | DATA_W | Logical write word |
| phy_wdata | output | DATA_W+1 | Physical write bus, spare column at the top bit |
| phy_rdata | input | DATA_W+1 | Physical read bus from the array |
| rdata | output | DATA_W | Logical read word |
| cfg_err | output | 1 | Last accepted load named an index out of range |

## Verification
The bench targets the ends of the shift range. Repair at column 0 shifts every bit. Repair at column N-1 moves only the top bit into the spare. An off-by-one decoder would leave one column unshifted or shift one column too many, and the bench would see a bit land in the wrong physical position. Per-column patterns that alternate between neighbouring columns expose a column that carries its neighbour's value. The bench loads out-of-range indices 8 and 15 to catch a decoder that wraps or partially shifts. It also issues a load while an access is in flight, to catch a design that lets the mapping change under a live access. A loop over every fault position then writes through a stuck column and reads back, which catches any mismatch between the write shift and the read shift.

// File: rtl/col_repair_pkg.sv
package col_repair_pkg;
  // Index width wide enough to also express out-of-range values (>= n).
  function automatic int unsigned addr_bits(input int unsigned n);
    return $clog2(n) + 1;
  endfunction
endpackage

// File: rtl/repair_cfg_reg.sv
module repair_cfg_reg #(
  parameter int unsigned N  = 8,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          en_in,
  input  logic [AW-1:0] addr_in,
  output logic          act_en,
  output logic [AW-1:0] act_addr,
  output logic          err
);
  localparam logic [AW-1:0] LIMIT = AW'(N);

  logic in_range;
  assign in_range = (addr_in < LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_en   <= 1'b0;
      act_addr <= '0;
      err      <= 1'b0;
    end else if (load) begin
      act_en   <= en_in && in_range;
      act_addr <= in_range ? addr_in : '0;
      err      <= en_in && !in_range;
    end
  end
endmodule

// File: rtl/repair_sel_decode.sv
module repair_sel_decode #(
  parameter int unsigned N  = 8,
  parameter int unsigned AW = 4
) (
  input  logic          act_en,
  input  logic [AW-1:0] act_addr,
  output logic [N-1:0]  sel
);
  for (genvar i = 0; i < N; i++) begin : g_therm
    assign sel[i] = act_en && (act_addr <= AW'(i));
  end
endmodule

// File: rtl/col_wr_shift.sv
module col_wr_shift #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] sel,
  output logic [N:0]   phy_wdata
);
  for (genvar j = 0; j <= N; j++) begin : g_col
    if (j == 0) begin : g_low
      assign phy_wdata[j] = sel[0] ? 1'b0 : wdata[0];
    end else if (j == N) begin : g_spare
      assign phy_wdata[j] = sel[N-1] ? wdata[N-1] : 1'b0;
    end else begin : g_mid
      assign phy_wdata[j] = !sel[j]  ? wdata[j]   :
                            sel[j-1] ? wdata[j-1] : 1'b0;
    end
  end
endmodule

// File: rtl/col_rd_shift.sv
module col_rd_shift #(
  parameter int unsigned N = 8
) (
  input  logic [N:0]   phy_rdata,
  input  logic [N-1:0] sel,
  output logic [N-1:0] rdata
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rdata[i] = sel[i] ? phy_rdata[i+1] : phy_rdata[i];
  end
endmodule

// File: rtl/col_shift_repair.sv
module col_shift_repair #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = col_repair_pkg::addr_bits(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              acc_active,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W:0]   phy_wdata,
  input  logic [DATA_W:0]   phy_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              cfg_err
);
  logic              load;
  logic              act_en;
  logic [ADDR_W-1:0] act_addr;
  logic [DATA_W-1:0] sel;

  assign load = cfg_we && !acc_active;

  repair_cfg_reg #(.N(DATA_W), .AW(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load), .en_in(cfg_en), .addr_in(cfg_addr),
    .act_en(act_en), .act_addr(act_addr), .err(cfg_err)
  );

  repair_sel_decode #(.N(DATA_W), .AW(ADDR_W)) u_dec (
    .act_en(act_en), .act_addr(act_addr), .sel(sel)
  );

  col_wr_shift #(.N(DATA_W)) u_wr (
    .wdata(wdata), .sel(sel), .phy_wdata(phy_wdata)
  );

  col_rd_shift #(.N(DATA_W)) u_rd (
    .phy_rdata(phy_rdata), .sel(sel), .rdata(rdata)
  );
endmodule

// File: rtl/col_shift_repair_chk.sv
module col_shift_repair_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_en,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              acc_active,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W:0]   phy_wdata,
  input logic [DATA_W:0]   phy_rdata,
  input logic [DATA_W-1:0] rdata,
  input logic              cfg_err,
  input logic              act_en,
  input logic [ADDR_W-1:0] act_addr,
  input logic [DATA_W-1:0] sel
);
  logic [DATA_W-1:0] low_keep;
  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      low_keep[i] = !act_en || (ADDR_W'(i) < act_addr);
  end

  // R2 / R9: an accepted load sets the error flag exactly for out-of-range enables
  a_r9_err_on_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !acc_active) |=> (cfg_err == $past(cfg_en && (cfg_addr >= ADDR_W'(DATA_W)))));

  // R3: loads under an access are dropped
  a_r3_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && acc_active) |=> ($stable(act_en) && $stable(act_addr) && $stable(cfg_err)));

  // R4: spare column carries 0 while repair is inactive
  a_r4_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |-> (phy_wdata[DATA_W] == 1'b0));

  // R5: columns below the fault stay on their own bit
  a_r5_low_unshifted: assert property (@(posedge clk) disable iff (!rst_n)
    ((phy_wdata[DATA_W-1:0] & low_keep) == (wdata & low_keep)));

  // R7: faulty column driven low
  a_r7_fault_col_zero: assert property (@(posedge clk) disable iff (!rst_n)
    act_en |-> (phy_wdata[act_addr] == 1'b0));

  // R8: select mask is a thermometer (set bits only above a set bit)
  a_r8_sel_thermo: assert property (@(posedge clk) disable iff (!rst_n)
    (((sel << 1) & ~sel) == '0));

  // R10: loopback of the physical bus returns the logical word
  a_r10_loopback: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_rdata == phy_wdata) |-> (rdata == wdata));
endmodule

bind col_shift_repair col_shift_repair_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_addr(cfg_addr),
  .acc_active(acc_active), .wdata(wdata), .phy_wdata(phy_wdata),
  .phy_rdata(phy_rdata), .rdata(rdata), .cfg_err(cfg_err),
  .act_en(act_en), .act_addr(act_addr), .sel(sel)
);

// File: tb/col_shift_repair_bench.sv
module col_shift_repair_bench;
  localparam int N  = 8;
  localparam int AW = 4;
  localparam int NV = 10;
  // entry: {en, addr[3:0], wdata[7:0], phy_rdata[8:0]}
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 4'd0,  8'hA5, 9'h1AA},
    {1'b0, 4'd5,  8'h3C, 9'h155},
    {1'b1, 4'd0,  8'hA5, 9'h0AA},
    {1'b1, 4'd0,  8'h5A, 9'h155},
    {1'b1, 4'd3,  8'hAA, 9'h12D},
    {1'b1, 4'd3,  8'h55, 9'h0D2},
    {1'b1, 4'd7,  8'hAA, 9'h155},
    {1'b1, 4'd7,  8'h55, 9'h0AA},
    {1'b1, 4'd8,  8'hC3, 9'h1F0},
    {1'b1, 4'd15, 8'h96, 9'h0F0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0, acc_active = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N:0]    phy_rdata = '0;
  logic [N:0]    phy_wdata;
  logic [N-1:0]  rdata;
  logic          cfg_err;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  col_shift_repair #(.DATA_W(N)) u_col_shift_repair (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_addr(cfg_addr),
    .acc_active(acc_active), .wdata(wdata), .phy_wdata(phy_wdata),
    .phy_rdata(phy_rdata), .rdata(rdata), .cfg_err(cfg_err)
  );

  function automatic logic [N:0] exp_wr(input logic en, input int a, input logic [N-1:0] d);
    logic [N:0] r;
    r = '0;
    for (int j = 0; j <= N; j++) begin
      if (!en || a >= N) r[j] = (j < N) ? d[j] : 1'b0;
      else if (j < a)    r[j] = d[j];
      else if (j == a)   r[j] = 1'b0;
      else               r[j] = d[j-1];
    end
    return r;
  endfunction

  function automatic logic [N-1:0] exp_rd(input logic en, input int a, input logic [N:0] p);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++)
      r[i] = (!en || a >= N || i < a) ? p[i] : p[i+1];
    return r;
  endfunction

  task automatic check(input string tag, input logic [N:0] act, input logic [N:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic load_cfg(input logic en, input logic [AW-1:0] a, input logic busy);
    @(negedge clk);
    cfg_en = en; cfg_addr = a; acc_active = busy; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; acc_active = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [N:0] mem [4];
    repeat (3) @(negedge clk);
    // R1 reset state
    wdata = 8'hA5; phy_rdata = 9'h15A; #1;
    check("R1 err", {8'b0, cfg_err}, 9'h0);
    check("R1 wr",  phy_wdata, 9'h0A5);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 rd",  {1'b0, rdata}, 9'h05A);

    for (int v = 0; v < NV; v++) begin
      logic en; int a; logic [N-1:0] d; logic [N:0] p; string tw, tr;
      en = VEC[v][21]; a = int'(VEC[v][20:17]); d = VEC[v][16:9]; p = VEC[v][8:0];
      load_cfg(en, VEC[v][20:17], 1'b0);
      wdata = d; phy_rdata = p; #1;
      tw = (!en || a >= N) ? "R4/R9 wr" : "R5/R6/R7 wr";
      tr = (!en || a >= N) ? "R4 rd"    : "R5/R8 rd";
      check({"R2 ", tw}, phy_wdata, exp_wr(en, a, d));
      check(tr, {1'b0, rdata}, {1'b0, exp_rd(en, a, p)});
      check("R9 err", {8'b0, cfg_err}, {8'b0, en && a >= N});
    end

    // R9: error cleared by a valid load
    load_cfg(1'b1, 4'd12, 1'b0); #1;
    check("R9 set", {8'b0, cfg_err}, 9'h1);
    load_cfg(1'b0, 4'd12, 1'b0); #1;
    check("R9 clear", {8'b0, cfg_err}, 9'h0);

    // R3: load under an access is dropped
    load_cfg(1'b1, 4'd2, 1'b0);
    load_cfg(1'b1, 4'd5, 1'b1);
    wdata = 8'hFF; #1;
    check("R3 map held", phy_wdata, 9'h1FB);
    load_cfg(1'b1, 4'd9, 1'b1); #1;
    check("R3 err held", {8'b0, cfg_err}, 9'h0);

    // R8: faulty column input has no effect on the read word
    phy_rdata = 9'h1F0; #1;
    check("R8 ignore", {1'b0, rdata}, 9'h0F8);
    phy_rdata = 9'h1F4; #1;
    check("R8 ignore", {1'b0, rdata}, 9'h0F8);

    // R10: every fault position, stuck-at-1 column, write then read
    for (int a = 0; a < N; a++) begin
      load_cfg(1'b1, AW'(a), 1'b0);
      for (int r = 0; r < 4; r++) begin
        wdata = 8'(8'h5A ^ (r * 8'h33) ^ a); #1;
        mem[r] = phy_wdata | (9'h1 << a);
      end
      for (int r = 0; r < 4; r++) begin
        phy_rdata = mem[r]; #1;
        check("R10 readback", {1'b0, rdata}, {1'b0, 8'(8'h5A ^ (r * 8'h33) ^ a)});
      end
    end
    finish_run();
  end
endmodule